// File: doc/BRIEF.md
# Trace Buffer Write Controller

This block drives the write side of a circular instruction trace store that sits inside a processor debug unit. Each cycle in which the core presents a trace entry for a retired instruction, the entry goes straight to the trace RAM's write port. It is written at the line named by a write pointer, and the pointer then steps forward, wrapping back to line zero after the last line. The RAM depth is a power of two set by a parameter, from 8 up to 65536 lines.

Software sees two 32-bit control words through a plain register port: `reg_sel` picks the word, reads are combinational and writes take effect at the next clock edge. Word 0 carries the write pointer and a 4-bit filter setting that is passed on to the trace filter. Word 1 carries a 3-bit limit, an overflow flag and a watchpoint enable. The limit is compared on every cycle with the upper three bits of the pointer. A match sets the sticky overflow flag. If the watchpoint enable and the global break-on-watchpoint input are both 1, the flag's rise also sends a one-cycle watchpoint request to the core. Word 1 may be rewritten at any time while tracing runs.

Top module: `trace_wr_ctrl`

## Requirements
- R1: While reset is asserted, both control words read as zero, `wp_req` is 0 and `filt_cfg` is 0.
- R2: In a cycle with `trc_valid` high, `ram_we` is 1, `ram_addr` equals the current pointer and `ram_wdata` equals `trc_data`. The pointer is one higher on the next cycle, and word 0 bits 15:0 return it.
- R3: A trace write at the last line (all address bits 1) moves the pointer to 0.
- R4: A write to word 0 (`reg_sel`=0) loads the pointer from `reg_wdata` bits ADDR_W-1:0 and the filter setting from bits 31:28. Reading word 0 then returns the filter in bits 31:28, the pointer zero-extended in bits 15:0 and zero elsewhere, and `filt_cfg` shows the filter.
- R5: When a word-0 write and a trace write fall in the same cycle, the pointer takes the written value and does not advance.
- R6: Word 1 (`reg_sel`=1) holds the watchpoint enable in bit 27, the limit in bits 26:24 and the overflow flag in bit 23. Writes to bit 23 and to bits 31:28 and 22:0 have no effect, and those bits read as 0.
- R7: If the limit equals pointer bits ADDR_W-1:ADDR_W-3, the overflow flag is 1 from the next cycle on. It stays 1 until word 1 is written.
- R8: A write to word 1 sets the flag to the result of comparing the newly written limit with the current pointer's upper three bits.
- R9: With the watchpoint enable and `glob_wp_en` both 1, `wp_req` goes high for exactly one cycle, in the same cycle the flag first reads 1.
- R10: If either the watchpoint enable or `glob_wp_en` is 0 when the flag rises, `wp_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trc_valid | input | 1 | A trace entry is presented this cycle |
| trc_data | input | DATA_W | Trace entry contents |
| ram_we | output | 1 | Trace RAM write enable |
| ram_addr | output | ADDR_W | Trace RAM line to write |
| ram_wdata | output | DATA_W | Trace RAM write data |
| reg_sel | input | 1 | Control word select: 0 = pointer word, 1 = overflow word |
| reg_we | input | 1 | Write the selected word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected word, read combinationally |
| glob_wp_en | input | 1 | Global break-on-watchpoint enable |
| wp_req | output | 1 | One-cycle watchpoint request |
| filt_cfg | output | 4 | Filter setting from word 0 |

## Verification
If the pointer goes wrong, it shows on `ram_addr` at the very next trace write and in word 0 at once. A wrong wrap or a lost priority shows up as an off-by-one address one cycle after the event. A wrong comparison slice or a broken sticky bit shows in word 1 bit 23 one cycle after the pointer enters or leaves the matching region. A gating fault shows as a missing, doubled or unwanted pulse on `wp_req` in that same cycle. For this reason the bench checks `wp_req` in the exact cycle before, at and after each flag rise, not in a window.

// File: rtl/trace_wr_ctrl.sv
module trace_wr_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              glob_wp_en,
  output logic              wp_req,
  output logic [3:0]        filt_cfg
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ptr_q;
  logic [3:0]        filt_q;
  logic [2:0]        lim_q;
  logic              wo_q, ovf_q, wp_q;

  logic       wr0, wr1, ovf_d;
  logic [2:0] top;

  assign wr0 = reg_we & ~reg_sel;
  assign wr1 = reg_we & reg_sel;
  assign top = ptr_q[ADDR_W-1 -: 3];

  assign ovf_d = wr1 ? (reg_wdata[26:24] == top) : (ovf_q | (lim_q == top));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      filt_q <= '0;
    end else if (wr0) begin
      ptr_q  <= reg_wdata[ADDR_W-1:0];
      filt_q <= reg_wdata[31:28];
    end else if (trc_valid) begin
      ptr_q  <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      wo_q  <= 1'b0;
      ovf_q <= 1'b0;
      wp_q  <= 1'b0;
    end else begin
      if (wr1) begin
        lim_q <= reg_wdata[26:24];
        wo_q  <= reg_wdata[27];
      end
      ovf_q <= ovf_d;
      wp_q  <= ovf_d & ~ovf_q & wo_q & glob_wp_en;
    end
  end

  assign ram_we    = trc_valid;
  assign ram_addr  = ptr_q;
  assign ram_wdata = trc_data;
  assign wp_req    = wp_q;
  assign filt_cfg  = filt_q;

  assign reg_rdata = reg_sel ? {4'b0, wo_q, lim_q, ovf_q, 23'b0}
                             : {filt_q, 12'b0, 16'(ptr_q)};

endmodule

module trace_wr_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trc_valid,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [ADDR_W-1:0] ptr_wr,
  input logic              glob_wp_en,
  input logic              wp_req,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              ovf_q,
  input logic              wo_q
);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && !(reg_we && !reg_sel) && !(&ptr_q)) |=> ptr_q == $past(ptr_q) + 1'b1);

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && !(reg_we && !reg_sel) && (&ptr_q)) |=> ptr_q == '0);

  // R5
  sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> ptr_q == $past(ptr_wr));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(reg_we && reg_sel)) |=> ovf_q);

  // R9
  wp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |=> !wp_req);

  // R9
  wp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |-> ovf_q && !$past(ovf_q));

  // R10
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |-> $past(glob_wp_en) && $past(wo_q));

endmodule

bind trace_wr_ctrl trace_wr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trc_valid  (trc_valid),
  .reg_sel    (reg_sel),
  .reg_we     (reg_we),
  .ptr_wr     (reg_wdata[ADDR_W-1:0]),
  .glob_wp_en (glob_wp_en),
  .wp_req     (wp_req),
  .ptr_q      (ptr_q),
  .ovf_q      (ovf_q),
  .wo_q       (wo_q)
);

// File: tb/tb_trace_wr_ctrl.sv
module tb_trace_wr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trc_valid = 1'b0;
  logic [DATA_W-1:0] trc_data = '0;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic              reg_sel = 1'b0;
  logic              reg_we = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              glob_wp_en = 1'b0;
  logic              wp_req;
  logic [3:0]        filt_cfg;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_data(trc_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .glob_wp_en(glob_wp_en), .wp_req(wp_req), .filt_cfg(filt_cfg)
  );

  // ops: 0 trace (exp = ram_addr), 1 write word0, 2 write word1, 3 read word0, 4 read word1
  localparam int NV = 16;
  localparam logic [2:0]  V_OP [NV] = '{2, 4, 0, 0, 3, 1, 3, 4, 0, 0, 0, 0, 3, 4, 2, 4};
  localparam logic [31:0] V_DAT[NV] = '{32'h0700_0000, 0, 32'hA5A5_0001, 32'hA5A5_0002, 0,
                                        32'hF00F_FF3D, 0, 0, 32'h1111_0001, 32'h2222_0002,
                                        32'h3333_0003, 32'h4444_0004, 0, 0, 32'hF780_0000, 0};
  localparam logic [31:0] V_EXP[NV] = '{0, 32'h0700_0000, 0, 1, 32'h0000_0002, 0,
                                        32'hF000_003D, 32'h0780_0000, 61, 62, 63, 0,
                                        32'hF000_0001, 32'h0780_0000, 0, 32'h0700_0000};
  localparam int          V_REQ[NV] = '{8, 6, 2, 2, 2, 4, 4, 7, 2, 2, 2, 3, 3, 7, 8, 6};

  function automatic string rq(int i);
    case (i)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic sel, logic [31:0] exp, string req);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    tick(); tick();
    rd(0, 32'h0, "R1");
    rd(1, 32'h0, "R1");
    check("R1", {31'b0, wp_req}, 0);
    check("R1", {28'b0, filt_cfg}, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      case (V_OP[i])
        3'd0: begin
          trc_valid = 1'b1; trc_data = V_DAT[i];
          #1;
          check(rq(V_REQ[i]), 32'(ram_addr), V_EXP[i]);
          check(rq(V_REQ[i]), {ram_we, ram_wdata[30:0]}, {1'b1, V_DAT[i][30:0]});
          tick();
          trc_valid = 1'b0;
        end
        3'd1: wr(1'b0, V_DAT[i]);
        3'd2: wr(1'b1, V_DAT[i]);
        3'd3: begin rd(1'b0, V_EXP[i], rq(V_REQ[i])); tick(); end
        default: begin rd(1'b1, V_EXP[i], rq(V_REQ[i])); tick(); end
      endcase
    end

    // R4 filter output
    check("R4", {28'b0, filt_cfg}, 32'hF);

    // R5 software write wins over trace advance (pointer is 1 here)
    trc_valid = 1'b1; reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'h0000_0005;
    tick();
    trc_valid = 1'b0; reg_we = 1'b0;
    rd(0, 32'h0000_0005, "R5");

    // R9 watchpoint pulse on flag rise
    glob_wp_en = 1'b1;
    wr(1'b1, 32'h0F00_0000);
    wr(1'b0, 32'd56);
    check("R9", {31'b0, wp_req}, 0);
    tick();
    check("R9", {31'b0, wp_req}, 1);
    rd(1, 32'h0F80_0000, "R9");
    tick();
    check("R9", {31'b0, wp_req}, 0);

    // R10 global enable off
    glob_wp_en = 1'b0;
    wr(1'b1, 32'h0B00_0000);
    wr(1'b0, 32'd24);
    tick();
    check("R10", {31'b0, wp_req}, 0);
    rd(1, 32'h0B80_0000, "R10");

    // R10 local enable off
    glob_wp_en = 1'b1;
    wr(1'b1, 32'h0500_0000);
    wr(1'b0, 32'd40);
    tick();
    check("R10", {31'b0, wp_req}, 0);
    rd(1, 32'h0580_0000, "R10");

    summary();
    $finish;
  end
endmodule